// File: doc/BRIEF.md
# Differential PCM Sample Codec

This block compresses a stream of 8-bit signed samples into 4-bit difference codes and rebuilds samples from such codes. The encoder holds a prediction, which is the last sample it has reconstructed. At each sample instant it subtracts that prediction from the incoming sample. It divides the result by a fixed step and clips it to a 4-bit code. It then moves its prediction by the code times the step. The decoder keeps an identical prediction register and moves it by the same amount for every code it receives. As a result, the decoder's output follows the encoder's own reconstruction exactly.

Sample instants come from a divider on a system clock enable. The enable is first divided by 1, 2, 4 or 8, which gives one of four selectable base clock rates. A sample instant then occurs once every 32 ticks of that base clock. Lower base rates space the samples further apart, so a fast-moving input is followed more coarsely. The encoder output and the decoder input are separate ports, so the two halves can be looped back or driven independently.

Top module: `dpcm_codec`

## Requirements
- R1: A sample instant occurs on every 32nd base tick. When `in_valid` is high at a sample instant, `code_valid` pulses high for exactly one clock cycle, starting in the cycle after that sample instant.
- R2: The base tick divides `clk_en` by 1, 2, 4 or 8 for `rate_sel` values 0, 1, 2 and 3. With `clk_en` held high, codes are therefore 32, 64, 128 or 256 clocks apart.
- R3: `code_out` is a 4-bit two's complement value. It equals (sample − prediction) / STEP, with the division truncated toward zero.
- R4: A quotient above +7 gives the code +7 (4'b0111). A quotient below −8 gives the code −8 (4'b1000).
- R5: The encoder's prediction advances by code × STEP and not by the raw input, so the next difference is taken against the reconstruction.
- R6: One cycle after `code_in_valid` is high, `recon_valid` pulses high. In that same cycle, `recon_out` shows the previous reconstruction plus `code_in` × STEP.
- R7: Both predictions clip at +127 and −128 and never wrap around.
- R8: While `rst_n` is low, both predictions are cleared to 0, `code_out` reads 0, and both valid outputs are low.
- R9: A sample instant with `in_valid` low produces no code and leaves the encoder's prediction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | System clock enable, divided down to the base tick |
| rate_sel | input | 2 | Base tick divisor select: 0 → /1, 1 → /2, 2 → /4, 3 → /8 |
| in_valid | input | 1 | `sample_in` holds a sample to encode |
| sample_in | input | 8 | Signed input sample |
| code_out | output | 4 | Signed difference code |
| code_valid | output | 1 | One-cycle qualifier for `code_out` |
| code_in | input | 4 | Signed difference code to decode |
| code_in_valid | input | 1 | Qualifier for `code_in` |
| recon_out | output | 8 | Decoder reconstruction |
| recon_valid | output | 1 | Pulses when `recon_out` has just been updated |

## Verification
Predictor clipping cannot be reached through a looped-back encoder. Because the quantizer truncates toward zero, code × STEP never overshoots the input sample, so the reconstruction always stays within the sample range. To reach clipping, the bench breaks the loopback and drives runs of +7 and −8 codes straight into the decoder. Those runs push the decoder's prediction past +127 and −128. The encoder's code clip is reached by large steps in the input, first from zero up to near full scale and then down to full negative scale. The rate divisor is measured as the gap in clocks between two consecutive codes, both with `clk_en` held high and with `clk_en` toggling.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;
  localparam int SMP_W  = 8;
  localparam int CODE_W = 4;
  localparam int ACC_W  = 16;
  localparam int RSEL_W = 2;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [CODE_W-1:0] code_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  localparam acc_t CODE_HI = acc_t'((1 << (CODE_W - 1)) - 1);
  localparam acc_t CODE_LO = -CODE_HI - acc_t'(1);
  localparam acc_t SMP_HI  = acc_t'((1 << (SMP_W - 1)) - 1);
  localparam acc_t SMP_LO  = -SMP_HI - acc_t'(1);

  // sample minus prediction, widened so no bit is lost
  function automatic acc_t diff_of(smp_t x, smp_t p);
    return acc_t'(x) - acc_t'(p);
  endfunction

  // uniform quantizer: truncating divide, then clip to code range
  function automatic code_t quantize(acc_t d, acc_t step);
    acc_t q;
    q = d / step;
    if (q > CODE_HI)      q = CODE_HI;
    else if (q < CODE_LO) q = CODE_LO;
    return code_t'(q);
  endfunction

  function automatic acc_t dequant(code_t c, acc_t step);
    return acc_t'(c) * step;
  endfunction

  // prediction update that clips at the sample range
  function automatic smp_t sat_add(smp_t p, acc_t d);
    acc_t s;
    s = acc_t'(p) + d;
    if (s > SMP_HI)      s = SMP_HI;
    else if (s < SMP_LO) s = SMP_LO;
    return smp_t'(s);
  endfunction
endpackage

// File: rtl/dpcm_rate_gen.sv
module dpcm_rate_gen
  import dpcm_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [RSEL_W-1:0] rate_sel,
  output logic              kit_tick,
  output logic              strobe
);
  localparam int PRE_W  = (1 << RSEL_W) - 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  logic [PRE_W-1:0]  pre_cnt;
  logic [PRE_W-1:0]  pre_mask;
  logic [SLOT_W-1:0] slot_cnt;

  // thermometer mask: bit i set when divisor exceeds 2**i
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign pre_mask[i] = (int'(rate_sel) > i);
  end

  assign kit_tick = clk_en && ((pre_cnt & pre_mask) == pre_mask);
  assign strobe   = kit_tick && (slot_cnt == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      slot_cnt <= '0;
    end else begin
      if (clk_en)   pre_cnt  <= pre_cnt + 1'b1;
      if (kit_tick) slot_cnt <= strobe ? '0 : slot_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dpcm_predictor.sv
module dpcm_predictor
  import dpcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  acc_t delta,
  output smp_t pred_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    pred_o <= '0;
    else if (load) pred_o <= sat_add(pred_o, delta);
  end
endmodule

// File: rtl/dpcm_encoder.sv
module dpcm_encoder
  import dpcm_pkg::*;
#(
  parameter int STEP = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe,
  input  logic  in_valid,
  input  smp_t  sample_in,
  output code_t code_o,
  output logic  valid_o,
  output logic  fire_o,
  output acc_t  diff_o,
  output smp_t  pred_o
);
  localparam acc_t STEP_A = acc_t'(STEP);

  code_t code_d;
  acc_t  delta_d;

  assign fire_o  = strobe && in_valid;
  assign diff_o  = diff_of(sample_in, pred_o);
  assign code_d  = quantize(diff_o, STEP_A);
  assign delta_d = dequant(code_d, STEP_A);

  // closed loop: prediction moves by the dequantized code only
  dpcm_predictor pred_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (fire_o),
    .delta  (delta_d),
    .pred_o (pred_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= fire_o;
      if (fire_o) code_o <= code_d;
    end
  end
endmodule

// File: rtl/dpcm_decoder.sv
module dpcm_decoder
  import dpcm_pkg::*;
#(
  parameter int STEP = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_in,
  input  logic  code_valid,
  output smp_t  recon_o,
  output logic  valid_o,
  output acc_t  delta_o
);
  assign delta_o = dequant(code_in, acc_t'(STEP));

  dpcm_predictor pred_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (code_valid),
    .delta  (delta_o),
    .pred_o (recon_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= code_valid;
  end
endmodule

// File: rtl/dpcm_codec.sv
module dpcm_codec
  import dpcm_pkg::*;
#(
  parameter int STEP  = 4,
  parameter int SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [RSEL_W-1:0] rate_sel,
  input  logic              in_valid,
  input  logic [SMP_W-1:0]  sample_in,
  output logic [CODE_W-1:0] code_out,
  output logic              code_valid,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_in_valid,
  output logic [SMP_W-1:0]  recon_out,
  output logic              recon_valid
);
  // internal events brought out for the checker
  logic  kit_tick;
  logic  strobe;
  logic  enc_fire;
  acc_t  enc_diff;
  smp_t  enc_pred;
  code_t enc_code;
  smp_t  dec_recon;
  acc_t  dec_delta;

  dpcm_rate_gen #(.SLOTS(SLOTS)) rate_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .rate_sel (rate_sel),
    .kit_tick (kit_tick),
    .strobe   (strobe)
  );

  dpcm_encoder #(.STEP(STEP)) enc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .in_valid  (in_valid),
    .sample_in (smp_t'(sample_in)),
    .code_o    (enc_code),
    .valid_o   (code_valid),
    .fire_o    (enc_fire),
    .diff_o    (enc_diff),
    .pred_o    (enc_pred)
  );

  dpcm_decoder #(.STEP(STEP)) dec_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_in    (code_t'(code_in)),
    .code_valid (code_in_valid),
    .recon_o    (dec_recon),
    .valid_o    (recon_valid),
    .delta_o    (dec_delta)
  );

  assign code_out  = enc_code;
  assign recon_out = dec_recon;
endmodule

// File: rtl/dpcm_codec_chk.sv
module dpcm_codec_chk
  import dpcm_pkg::*;
#(
  parameter int STEP  = 4,
  parameter int SLOTS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kit_tick,
  input logic              strobe,
  input logic              enc_fire,
  input acc_t              enc_diff,
  input smp_t              enc_pred,
  input logic [CODE_W-1:0] code_out,
  input logic              code_valid,
  input logic              code_in_valid,
  input logic [SMP_W-1:0]  recon_out,
  input logic              recon_valid,
  input acc_t              dec_delta
);
  localparam acc_t HI_LIM = CODE_HI * acc_t'(STEP);
  localparam acc_t LO_LIM = CODE_LO * acc_t'(STEP);
  localparam logic [CODE_W-1:0] CODE_HI_B = CODE_W'(CODE_HI);
  localparam logic [CODE_W-1:0] CODE_LO_B = CODE_W'(CODE_LO);

  // base ticks seen since the last sample instant
  logic [15:0] tick_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)        tick_cnt <= '0;
    else if (strobe)   tick_cnt <= '0;
    else if (kit_tick) tick_cnt <= tick_cnt + 1'b1;
  end

  assert_strobe_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (tick_cnt == 16'(SLOTS - 1)));

  assert_code_after_fire_R1: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> $past(enc_fire));

  assert_code_clip_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_fire && (enc_diff > HI_LIM)) |=> (code_out == CODE_HI_B));

  assert_code_clip_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_fire && (enc_diff < LO_LIM)) |=> (code_out == CODE_LO_B));

  assert_recon_after_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    recon_valid |-> $past(code_in_valid));

  assert_no_wrap_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_in_valid) && !$past(recon_out[SMP_W-1]) && !$past(dec_delta[ACC_W-1]))
      |-> !recon_out[SMP_W-1]);

  assert_no_wrap_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_in_valid) && $past(recon_out[SMP_W-1]) && $past(dec_delta[ACC_W-1]))
      |-> recon_out[SMP_W-1]);

  assert_pred_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enc_fire) |-> $stable(enc_pred));
endmodule

bind dpcm_codec dpcm_codec_chk #(.STEP(STEP), .SLOTS(SLOTS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .kit_tick      (kit_tick),
  .strobe        (strobe),
  .enc_fire      (enc_fire),
  .enc_diff      (enc_diff),
  .enc_pred      (enc_pred),
  .code_out      (code_out),
  .code_valid    (code_valid),
  .code_in_valid (code_in_valid),
  .recon_out     (recon_out),
  .recon_valid   (recon_valid),
  .dec_delta     (dec_delta)
);

// File: tb/dpcm_codec_tb_top.sv
module dpcm_codec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic       in_valid = 1'b0;
  logic [7:0] sample_in = 8'd0;
  logic [3:0] code_out;
  logic       code_valid;
  logic [3:0] code_in;
  logic       code_in_valid;
  logic [7:0] recon_out;
  logic       recon_valid;

  logic       byp = 1'b0;
  logic [3:0] byp_code = 4'd0;
  logic       byp_valid = 1'b0;
  logic       gate_en = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign code_in       = byp ? byp_code  : code_out;
  assign code_in_valid = byp ? byp_valid : code_valid;

  always @(negedge clk) clk_en <= gate_en ? ~clk_en : 1'b1;

  dpcm_codec dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rate_sel(rate_sel),
    .in_valid(in_valid), .sample_in(sample_in),
    .code_out(code_out), .code_valid(code_valid),
    .code_in(code_in), .code_in_valid(code_in_valid),
    .recon_out(recon_out), .recon_valid(recon_valid)
  );

  // STEP = 4: inputs, expected codes and expected reconstructions from reset
  localparam int NV = 12;
  localparam int VEC_X[NV] = '{10, 40, 40, 38,  0, -100, -128, -128, -128, -128, -128,  127};
  localparam int VEC_C[NV] = '{ 2,  7,  1,  0, -8,   -8,   -8,   -8,   -8,   -2,    0,    7};
  localparam int VEC_R[NV] = '{ 8, 36, 40, 40,  8,  -24,  -56,  -88, -120, -128, -128, -100};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  // wait at negedges for code_valid; returns cycles waited or -1
  task automatic wait_code(output int n);
    n = -1;
    for (int i = 1; i <= 2000; i++) begin
      @(negedge clk);
      if (code_valid) begin n = i; break; end
    end
  endtask

  // encode one sample through the loopback and check code and reconstruction
  task automatic enc_step(string req, int x, int ec, int er);
    int n;
    sample_in = 8'(x);
    in_valid  = 1'b1;
    wait_code(n);
    if (n < 0) begin chk({req, " code timeout"}, 0, 1); return; end
    chk({req, " code"}, int'($signed(code_out)), ec);
    @(negedge clk);
    chk({req, " code_valid one cycle"}, int'(code_valid), 0);
    chk({req, " recon_valid"}, int'(recon_valid), 1);
    chk({req, " recon"}, int'($signed(recon_out)), er);
  endtask

  task automatic dec_step(string req, int c, int er);
    byp_code  = 4'(c);
    byp_valid = 1'b1;
    @(negedge clk);
    byp_valid = 1'b0;
    chk({req, " recon_valid"}, int'(recon_valid), 1);
    chk({req, " recon"}, int'($signed(recon_out)), er);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int n;
    int seen;
    repeat (3) @(negedge clk);
    // R8: outputs during reset
    chk("R8 code_out", int'(code_out), 0);
    chk("R8 code_valid", int'(code_valid), 0);
    chk("R8 recon_out", int'(recon_out), 0);
    chk("R8 recon_valid", int'(recon_valid), 0);
    rst_n = 1'b1;

    // R3 R4 R5 R6: table walk, loopback, rate 0
    for (int i = 0; i < NV; i++)
      enc_step($sformatf("R3/R4/R5 vec%0d", i), VEC_X[i], VEC_C[i], VEC_R[i]);

    // R9: sample instant with in_valid low gives no code, prediction held
    in_valid = 1'b0;
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (code_valid) seen++;
    end
    chk("R9 no code while invalid", seen, 0);
    enc_step("R9 prediction held", -92, 2, -92);

    // R1 R2: code spacing per rate select with clk_en high
    sample_in = 8'(-92);
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      wait_code(n);
      wait_code(n);
      wait_code(n);
      chk($sformatf("R1/R2 spacing rate%0d", r), n, 32 << r);
    end
    // R2: clk_en toggling halves the rate
    rate_sel = 2'd0;
    gate_en = 1'b1;
    wait_code(n);
    wait_code(n);
    wait_code(n);
    chk("R2 spacing with gated clk_en", n, 64);
    gate_en = 1'b0;
    in_valid = 1'b0;

    // R8: reset clears both predictions
    do_reset();
    chk("R8 recon after reset", int'(recon_out), 0);
    enc_step("R8 encoder prediction cleared", 10, 2, 8);
    in_valid = 1'b0;

    // R7 R6: decoder driven directly into both limits
    do_reset();
    @(negedge clk);
    byp = 1'b1;
    dec_step("R6 +7", 7, 28);
    dec_step("R6 +7", 7, 56);
    dec_step("R6 +7", 7, 84);
    dec_step("R6 +7", 7, 112);
    dec_step("R7 clip high", 7, 127);
    dec_step("R7 hold high", 7, 127);
    dec_step("R6 -1", -1, 123);
    do_reset();
    dec_step("R6 -8", -8, -32);
    dec_step("R6 -8", -8, -64);
    dec_step("R6 -8", -8, -96);
    dec_step("R6 -8", -8, -128);
    dec_step("R7 clip low", -8, -128);
    dec_step("R6 +1", 1, -124);
    @(negedge clk);
    chk("R6 recon_valid drops", int'(recon_valid), 0);
    byp = 1'b0;

    done = 1;
    summary();
    $finish;
  end
endmodule